// File: doc/BRIEF.md
# Programmable Trigger Sequencer

This block is the trigger engine of a logic-analyzer acquisition path. Each sample clock it looks at three word-match inputs (A, B, C) and a glitch-detect input. These events can be gated by a qualifier input whose polarity is selectable. The block folds the events together with its current sequence state into an index into a 16-entry, host-writable program table. The entry found there gives the next sequence state, a mask of sticky condition flags to set, and two action bits. One action bit fires the trigger at once. The other decrements an event count and fires the trigger when that count runs out.

A single 16-bit counter serves two purposes. Before the trigger it holds the number of events still needed. After the trigger it holds the number of post-trigger samples still to wait. When that wait ends, the block emits a one-cycle completion pulse and then stays idle until it is rearmed. A host loads the program table and both counter preloads through a byte-wide write port. A rearm strobe starts a new run.

Top module: `trig_seq_engine`

## Requirements
- R1: After reset or a rearm strobe, `seq_state` is 0, `flags` is 0, `trig_out` and `done_pulse` are 0, and `cnt_value` holds the event preload (0 after reset). A rearm takes priority over any event in the same cycle.
- R2: A sample has an event when any of A, B, C or glitch is high and the qualifier passes. The event code is 1 for A, 2 for B, 3 for C and 0 for glitch alone, with priority A > B > C > glitch. The table index is `seq_state*4 + code`.
- R3: A sample with no event leaves `seq_state`, `flags` and `cnt_value` unchanged.
- R4: Each table entry is packed as bit 7:6 next state, bits 5:2 flag mask, bit 1 fire-now and bit 0 count-event. `flags[3:0]` map to A, B, C and glitch. On an event, `flags` is ORed with the mask, and the flags stay set until rearm.
- R5: With `qual_en` high, events count only when `qual_in ^ qual_pol` is 1, so `qual_pol=1` selects active-low. With `qual_en` low, the qualifier has no effect.
- R6: An event whose entry has count-event set decrements `cnt_value` while it is above 1. When it is 1 or 0, that event fires the trigger instead.
- R7: When the trigger fires, `trig_out` goes high on that clock edge and stays high until rearm, and `cnt_value` is loaded with the delay preload.
- R8: After the trigger, `cnt_value` drops by one each cycle until it reaches 0. The next cycle then raises `done_pulse` for exactly one cycle. With delay D, that pulse follows D+1 edges after the trigger edge. From the trigger onward, events no longer change `seq_state` or `flags`.
- R9: A rearm reloads `cnt_value` from the event preload value written most recently.
- R10: The write port maps addresses 0 to 15 to the table entries. Addresses 16 and 17 hold the event preload (low byte, high byte), and 18 and 19 hold the delay preload. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| rearm | input | 1 | Synchronous restart of a trigger run |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host write address |
| wr_data | input | 8 | Host write data |
| match_a | input | 1 | Word recognizer A hit |
| match_b | input | 1 | Word recognizer B hit |
| match_c | input | 1 | Word recognizer C hit |
| glitch | input | 1 | Glitch detect |
| qual_in | input | 1 | Qualifier signal |
| qual_en | input | 1 | Enable qualifier gating |
| qual_pol | input | 1 | Qualifier polarity (1 = active low) |
| trig_out | output | 1 | Sticky trigger-satisfied flag |
| done_pulse | output | 1 | One-cycle post-trigger delay completion |
| flags | output | 4 | Sticky condition flags {A,B,C,glitch} |
| seq_state | output | 2 | Current sequence state |
| cnt_value | output | 16 | Event/delay counter contents |

## Verification
The bench applies A and B together and expects the A-coded entry. A design with the priority order reversed would follow the B row and end in the wrong state. It sets the event count so the trigger must fire on the event seen at count 1. An off-by-one counter would fire one event early or one event late. It runs delays of 0 and 2 and checks the exact cycle of the single completion pulse. A design with a stray decrement, or a pulse that repeats, would miss that cycle or produce a second pulse. It also drives matches during the delay, drives an event in the same cycle as a rearm, writes the preload high byte, and writes to an unmapped address. These catch designs that keep sequencing after the trigger, that let the event win over the rearm, or that decode addresses loosely.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
   localparam int STATE_W = 2;
   localparam int NFLAG   = 4;
   localparam int CODE_W  = 2;
   localparam int IDX_W   = STATE_W + CODE_W;
   localparam int DEPTH   = 1 << IDX_W;
   localparam int ENTRY_W = STATE_W + NFLAG + 2;

   typedef struct packed {
      logic [STATE_W-1:0] nxt;
      logic [NFLAG-1:0]   mask;
      logic               fire;
      logic               count;
   } seq_entry_t;

   typedef enum logic [1:0] {
      PH_ARMED = 2'd0,
      PH_DELAY = 2'd1,
      PH_HALT  = 2'd2
   } phase_e;
endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
   import trig_seq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output seq_entry_t         rd_entry,
   output logic [CNT_W-1:0]   evt_preload,
   output logic [CNT_W-1:0]   dly_preload
);
   localparam int NB       = CNT_W / 8;
   localparam int EVT_BASE = DEPTH;
   localparam int DLY_BASE = DEPTH + NB;

   logic [ENTRY_W-1:0] tbl_q [DEPTH];
   logic [7:0]         evt_q [NB];
   logic [7:0]         dly_q [NB];

   generate
      if (ENTRY_W != 8) begin : g_bad_entry
         $error("table entry must be one byte wide");
      end
      if ((1 << ADDR_W) < DLY_BASE + NB) begin : g_bad_addr
         $error("address width too small for register map");
      end

      for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
         localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
         always_ff @(posedge clk) begin
            if (rst)
               tbl_q[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
               tbl_q[i] <= wr_data;
         end
      end

      for (genvar j = 0; j < NB; j++) begin : g_pre
         localparam logic [ADDR_W-1:0] EVT_ADDR = ADDR_W'(EVT_BASE + j);
         localparam logic [ADDR_W-1:0] DLY_ADDR = ADDR_W'(DLY_BASE + j);
         always_ff @(posedge clk) begin
            if (rst) begin
               evt_q[j] <= '0;
               dly_q[j] <= '0;
            end else if (wr_en) begin
               if (wr_addr == EVT_ADDR) evt_q[j] <= wr_data;
               if (wr_addr == DLY_ADDR) dly_q[j] <= wr_data;
            end
         end
         assign evt_preload[8*j +: 8] = evt_q[j];
         assign dly_preload[8*j +: 8] = dly_q[j];
      end
   endgenerate

   assign rd_entry = seq_entry_t'(tbl_q[rd_idx]);
endmodule

// File: rtl/trig_seq_evsel.sv
module trig_seq_evsel
   import trig_seq_pkg::*;
#(
   parameter bit HAS_QUAL = 1'b1
) (
   input  logic              match_a,
   input  logic              match_b,
   input  logic              match_c,
   input  logic              glitch,
   input  logic              qual_in,
   input  logic              qual_en,
   input  logic              qual_pol,
   output logic              hit,
   output logic [CODE_W-1:0] code
);
   logic qual_ok;
   logic any_raw;

   generate
      if (HAS_QUAL) begin : g_qual
         assign qual_ok = !qual_en || (qual_in ^ qual_pol);
      end else begin : g_noqual
         logic unused_q;
         assign unused_q = qual_in ^ qual_en ^ qual_pol;
         assign qual_ok  = 1'b1;
      end
   endgenerate

   assign any_raw = match_a | match_b | match_c | glitch;
   assign hit     = any_raw & qual_ok;

   always_comb begin
      if (match_a)      code = 2'd1;
      else if (match_b) code = 2'd2;
      else if (match_c) code = 2'd3;
      else              code = 2'd0;
   end
endmodule

// File: rtl/trig_seq_counter.sv
module trig_seq_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_evt,
   input  logic             ld_dly,
   input  logic             dec,
   input  logic [CNT_W-1:0] evt_val,
   input  logic [CNT_W-1:0] dly_val,
   output logic [CNT_W-1:0] cnt,
   output logic             le_one,
   output logic             zero
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (ld_evt)
         cnt <= evt_val;
      else if (ld_dly)
         cnt <= dly_val;
      else if (dec && cnt != '0)
         cnt <= cnt - ONE;
   end

   assign zero   = (cnt == '0);
   assign le_one = (cnt <= ONE);
endmodule

// File: rtl/trig_seq_engine.sv
module trig_seq_engine
   import trig_seq_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit HAS_QUAL = 1'b1,
   parameter int ADDR_W   = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               rearm,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   input  logic               match_a,
   input  logic               match_b,
   input  logic               match_c,
   input  logic               glitch,
   input  logic               qual_in,
   input  logic               qual_en,
   input  logic               qual_pol,
   output logic               trig_out,
   output logic               done_pulse,
   output logic [NFLAG-1:0]   flags,
   output logic [STATE_W-1:0] seq_state,
   output logic [CNT_W-1:0]   cnt_value
);
   generate
      if (CNT_W < 8 || (CNT_W % 8) != 0) begin : g_bad_cnt
         $error("CNT_W must be a nonzero multiple of 8");
      end
   endgenerate

   phase_e             phase_q;
   seq_entry_t         entry;
   logic [CNT_W-1:0]   evt_pre, dly_pre;
   logic               hit;
   logic [CODE_W-1:0]  code;
   logic [IDX_W-1:0]   idx;
   logic               armed, fire, dec, cnt_le1, cnt_zero;

   assign idx = {seq_state, code};

   trig_seq_cfg #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_idx     (idx),
      .rd_entry   (entry),
      .evt_preload(evt_pre),
      .dly_preload(dly_pre)
   );

   trig_seq_evsel #(.HAS_QUAL(HAS_QUAL)) u_evsel (
      .match_a (match_a),
      .match_b (match_b),
      .match_c (match_c),
      .glitch  (glitch),
      .qual_in (qual_in),
      .qual_en (qual_en),
      .qual_pol(qual_pol),
      .hit     (hit),
      .code    (code)
   );

   always_comb begin
      armed = (phase_q == PH_ARMED) && hit && !rearm;
      fire  = armed && (entry.fire || (entry.count && cnt_le1));
      dec   = !rearm &&
              ((armed && entry.count && !fire) ||
               (phase_q == PH_DELAY && !cnt_zero));
   end

   trig_seq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .ld_evt (rearm),
      .ld_dly (fire),
      .dec    (dec),
      .evt_val(evt_pre),
      .dly_val(dly_pre),
      .cnt    (cnt_value),
      .le_one (cnt_le1),
      .zero   (cnt_zero)
   );

   always_ff @(posedge clk) begin
      if (rst || rearm) begin
         phase_q    <= PH_ARMED;
         seq_state  <= '0;
         flags      <= '0;
         trig_out   <= 1'b0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         unique case (phase_q)
            PH_ARMED: begin
               if (armed) begin
                  seq_state <= entry.nxt;
                  flags     <= flags | entry.mask;
               end
               if (fire) begin
                  trig_out <= 1'b1;
                  phase_q  <= PH_DELAY;
               end
            end
            PH_DELAY: begin
               if (cnt_zero) begin
                  done_pulse <= 1'b1;
                  phase_q    <= PH_HALT;
               end
            end
            default: phase_q <= PH_HALT;
         endcase
      end
   end
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk
   import trig_seq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               rearm,
   input logic               match_a,
   input logic               match_b,
   input logic               match_c,
   input logic               glitch,
   input logic               qual_in,
   input logic               qual_en,
   input logic               qual_pol,
   input logic               trig_out,
   input logic               done_pulse,
   input logic [NFLAG-1:0]   flags,
   input logic [STATE_W-1:0] seq_state,
   input logic [CNT_W-1:0]   cnt_value
);
   p_rearm_clear_r1: assert property (@(posedge clk) disable iff (rst)
      rearm |=> (flags == '0 && seq_state == '0 && !trig_out && !done_pulse));

   p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
      (!match_a && !match_b && !match_c && !glitch && !rearm && !trig_out)
      |=> ($stable(seq_state) && $stable(flags) && $stable(cnt_value)));

   p_flags_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      !rearm |=> ((flags & $past(flags)) == $past(flags)));

   p_qual_block_r5: assert property (@(posedge clk) disable iff (rst)
      (qual_en && !(qual_in ^ qual_pol) && !rearm && !trig_out)
      |=> ($stable(seq_state) && $stable(flags) && $stable(cnt_value)));

   p_trig_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (trig_out && !rearm) |=> trig_out);

   p_delay_step_r8: assert property (@(posedge clk) disable iff (rst)
      (trig_out && !done_pulse && cnt_value != '0 && !rearm)
      |=> (cnt_value == $past(cnt_value) - CNT_W'(1)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
      done_pulse |=> !done_pulse);

   p_done_needs_trig_r8: assert property (@(posedge clk) disable iff (rst)
      done_pulse |-> trig_out);

   p_frozen_after_trig_r8: assert property (@(posedge clk) disable iff (rst)
      (trig_out && !rearm) |=> ($stable(seq_state) && $stable(flags)));
endmodule

bind trig_seq_engine trig_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rearm     (rearm),
   .match_a   (match_a),
   .match_b   (match_b),
   .match_c   (match_c),
   .glitch    (glitch),
   .qual_in   (qual_in),
   .qual_en   (qual_en),
   .qual_pol  (qual_pol),
   .trig_out  (trig_out),
   .done_pulse(done_pulse),
   .flags     (flags),
   .seq_state (seq_state),
   .cnt_value (cnt_value)
);

// File: tb/trig_seq_engine_test.sv
`timescale 1ns/1ps
module trig_seq_engine_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rearm = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        match_a = 1'b0, match_b = 1'b0, match_c = 1'b0, glitch = 1'b0;
   logic        qual_in = 1'b0, qual_en = 1'b0, qual_pol = 1'b0;
   logic        trig_out, done_pulse;
   logic [3:0]  flags;
   logic [1:0]  seq_state;
   logic [15:0] cnt_value;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   trig_seq_engine uut (
      .clk(clk), .rst(rst), .rearm(rearm),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .match_a(match_a), .match_b(match_b), .match_c(match_c), .glitch(glitch),
      .qual_in(qual_in), .qual_en(qual_en), .qual_pol(qual_pol),
      .trig_out(trig_out), .done_pulse(done_pulse), .flags(flags),
      .seq_state(seq_state), .cnt_value(cnt_value)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic do_rearm();
      rearm = 1'b1;
      step();
      rearm = 1'b0;
   endtask

   task automatic ev(input logic a, input logic b, input logic c, input logic g);
      match_a = a; match_b = b; match_c = c; match_g_set(g);
      step();
      match_a = 1'b0; match_b = 1'b0; match_c = 1'b0; glitch = 1'b0;
   endtask

   task automatic match_g_set(input logic g);
      glitch = g;
   endtask

   task automatic t_reset();
      check("R1 reset trig", trig_out, 0);
      check("R1 reset done", done_pulse, 0);
      check("R1 reset flags", flags, 0);
      check("R1 reset state", seq_state, 0);
      check("R1 reset cnt", cnt_value, 0);
   endtask

   task automatic t_program();
      wr(5'd1, 8'h60);   // state0 A -> state1, flag A
      wr(5'd6, 8'h90);   // state1 B -> state2, flag B
      wr(5'd11, 8'h89);  // state2 C -> state2, flag C, count
      wr(5'd8, 8'h84);   // state2 glitch -> state2, flag G
      wr(5'd16, 8'h03);
      wr(5'd17, 8'h01);
      wr(5'd18, 8'h02);
      wr(5'd19, 8'h00);
      do_rearm();
      check("R10 R9 preload hi byte", cnt_value, 16'h0103);
      wr(5'd17, 8'h00);
      wr(5'd20, 8'hFF);  // unmapped
      do_rearm();
      check("R10 R9 preload reload", cnt_value, 16'h0003);
   endtask

   task automatic t_idle();
      step();
      check("R3 idle state", seq_state, 0);
      check("R3 idle flags", flags, 0);
   endtask

   task automatic t_sequence();
      ev(1, 0, 0, 0);
      check("R2 A to state1", seq_state, 1);
      check("R4 flag A", flags, 4'b1000);
      ev(1, 1, 0, 0);    // A wins over B: index 5 is empty -> state0
      check("R2 priority A over B", seq_state, 0);
      check("R4 empty mask keeps flags", flags, 4'b1000);
      ev(1, 0, 0, 0);
      ev(0, 1, 0, 0);
      check("R2 B to state2", seq_state, 2);
      check("R4 flags A B", flags, 4'b1100);
   endtask

   task automatic t_qual();
      qual_en = 1'b1; qual_pol = 1'b0; qual_in = 1'b0;
      ev(0, 0, 1, 0);
      check("R5 blocked cnt", cnt_value, 3);
      check("R5 blocked flags", flags, 4'b1100);
      qual_pol = 1'b1;
      ev(0, 0, 1, 0);
      check("R5 active-low pass cnt", cnt_value, 2);
      check("R5 flags C", flags, 4'b1110);
      ev(0, 0, 0, 1);
      check("R2 glitch code flags", flags, 4'b1111);
      check("R6 glitch no count", cnt_value, 2);
      qual_en = 1'b0; qual_in = 1'b0; qual_pol = 1'b0;
   endtask

   task automatic t_count_and_delay();
      ev(0, 0, 1, 0);
      check("R6 count to 1", cnt_value, 1);
      check("R6 no early trig", trig_out, 0);
      ev(0, 0, 1, 0);
      check("R6 R7 trig fires", trig_out, 1);
      check("R7 delay loaded", cnt_value, 2);
      ev(1, 1, 0, 0);
      check("R8 delay step", cnt_value, 1);
      check("R8 frozen state", seq_state, 2);
      check("R8 frozen flags", flags, 4'b1111);
      step();
      check("R8 delay zero", cnt_value, 0);
      check("R8 no early done", done_pulse, 0);
      step();
      check("R8 done pulse", done_pulse, 1);
      step();
      check("R8 done single", done_pulse, 0);
      check("R7 trig held", trig_out, 1);
   endtask

   task automatic t_fire_now();
      wr(5'd1, 8'h22);   // state0 A: flag A, fire now
      wr(5'd18, 8'h00);
      do_rearm();
      check("R1 rearm clears trig", trig_out, 0);
      check("R9 rearm reload", cnt_value, 3);
      ev(1, 0, 0, 0);
      check("R7 fire-now trig", trig_out, 1);
      check("R7 zero delay loaded", cnt_value, 0);
      step();
      check("R8 zero-delay done", done_pulse, 1);
      step();
      check("R8 zero-delay single", done_pulse, 0);
   endtask

   task automatic t_rearm_priority();
      rearm = 1'b1; match_a = 1'b1;
      step();
      rearm = 1'b0; match_a = 1'b0;
      check("R1 rearm beats event trig", trig_out, 0);
      check("R1 rearm beats event flags", flags, 0);
      check("R1 rearm beats event state", seq_state, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_program();
      t_idle();
      t_sequence();
      t_qual();
      t_count_and_delay();
      t_fire_now();
      t_rearm_priority();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule